// File: doc/BRIEF.md
# Serial Two-Wire Byte Memory Slave

This block is the target side of a two-wire serial bus (I2C) in front of a byte-wide register array of up to 2048 entries. It samples the SCL and SDA lines with the system clock and recognises the bus START and STOP conditions. It then decodes the select byte that follows a START and runs either a byte write or a sequential read against its internal array. The SDA line is only ever pulled low: the block drives an output enable that the pad turns into an open-drain pull-down.

The three select bits between the fixed device-type nibble and the direction bit are not a device number. They serve as the upper bits of the array address, and the parameter `MEM_BYTES` sets how many of them are used. An address pointer is kept across transfers. A write sets it, and both writes and reads advance it. A reader can therefore set the pointer with a short write, send STOP, and then read from that location. A write-protect pin freezes the array contents but leaves the bus handshake unchanged.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and the block ignores all bus traffic, including complete bytes, until it sees a START (SDA falling while SCL is high).
- R2: A STOP (SDA rising while SCL is high) releases SDA and returns the block to idle. Bytes clocked after a STOP and before the next START get no acknowledge.
- R3: The select byte is received MSB first. If its bits 7..4 equal 1010, the block acknowledges by pulling SDA low during the ninth SCL high phase. With any other value it gives no acknowledge and leaves SDA released until STOP.
- R4: `MEM_BYTES` may be 256, 512, 1024 or 2048. Select-byte bits 3..1 give the high address bits a10, a9, a8, and only as many as the array needs are used. The unused upper bits are don't-care.
- R5: Select-byte bit 0 picks the direction (0 = write, 1 = read). In a write, the byte after the select byte is the low eight address bits and is acknowledged.
- R6: Each later write byte is acknowledged and stored at the pointer, and the pointer then increments. The pointer wraps from `MEM_BYTES`-1 to 0.
- R7: In a read, the block sends the byte at the pointer MSB first. It releases SDA for a 1 and pulls it low for a 0 across each SCL high phase, and the pointer increments after each byte.
- R8: After each read byte, a low ninth bit from the master makes the block send the next byte. A high ninth bit makes it release SDA until STOP, so later clocked bytes read as 0xFF.
- R9: While `wp_i` is 1, write data bytes are still acknowledged but the array is not changed.
- R10: `sda_oe` changes only while the synchronised SCL is low.
- R11: The pointer keeps its value across STOP. A read that follows an address-only write starts at the written address, with the high bits taken from the read's select byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| wp_i | input | 1 | Write protect; 1 blocks array updates |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Multi-byte writes and reads check that data, acknowledges and pointer advance line up byte by byte. A write with a non-zero high select field, followed by reads with two different high fields at the same low address, shows whether those select bits really reach the array address. A write that starts at the last location and a read back at location zero exercise the wrap. A write with protect active, a wrong device nibble, and bytes clocked before any START or after a STOP each show the difference between acknowledging, storing and staying silent. A read ended by a high ninth bit, followed by one more clocked byte, confirms that the block lets go of the line.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_WAIT
  } bus_state_e;

  typedef enum logic [1:0] {
    RX_SEL, RX_ADDR, RX_DATA
  } rx_kind_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cm_cond.sv
module i2cm_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl;
      sda_p <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_p;
  assign scl_fall  = ~scl & scl_p;
  assign start_evt = scl & scl_p & sda_p & ~sda;
  assign stop_evt  = scl & scl_p & ~sda_p & sda;
endmodule

// File: rtl/i2cm_array.sv
module i2cm_array #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int MEM_BYTES = 2048,
  parameter int AW        = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          sda_lvl,
  input  logic          wp,
  input  logic [7:0]    rdata,
  output logic [AW-1:0] ptr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic          sda_oe,
  output logic          busy
);
  bus_state_e st;
  rx_kind_e   kind;
  logic [2:0] cnt;
  logic [7:0] shreg;
  logic       flag;   // byte complete (RX) or master asked for more (MACK)
  logic       rw;

  // Upper pointer bits come from select bits 3..1, as many as AW needs.
  function automatic logic [AW-1:0] set_hi(input logic [AW-1:0] p,
                                           input logic [7:0] sel);
    logic [AW-1:0] r;
    r = p;
    for (int i = 8; i < AW; i++) r[i] = sel[i-7];
    return r;
  endfunction

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind      <= RX_SEL;
      cnt       <= '0;
      shreg     <= '0;
      flag      <= 1'b0;
      rw        <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (stop_evt) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
        flag   <= 1'b0;
      end else begin
        case (st)
          ST_IDLE: begin
            if (start_evt) begin
              st   <= ST_RX;
              kind <= RX_SEL;
              cnt  <= '0;
              flag <= 1'b0;
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_lvl};
              cnt   <= cnt + 3'd1;
              if (cnt == 3'd7) flag <= 1'b1;
            end else if (scl_fall && flag) begin
              flag <= 1'b0;
              case (kind)
                RX_SEL: begin
                  if (shreg[7:4] == DEV_TYPE) begin
                    rw     <= shreg[0];
                    ptr    <= set_hi(ptr, shreg);
                    sda_oe <= 1'b1;
                    st     <= ST_ACK;
                  end else begin
                    st <= ST_WAIT;
                  end
                end
                RX_ADDR: begin
                  ptr[7:0] <= shreg;
                  sda_oe   <= 1'b1;
                  st       <= ST_ACK;
                end
                default: begin
                  mem_we    <= ~wp;
                  mem_waddr <= ptr;
                  mem_wdata <= shreg;
                  ptr       <= ptr + 1'b1;
                  sda_oe    <= 1'b1;
                  st        <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == RX_SEL && rw) begin
                st     <= ST_TX;
                shreg  <= rdata;
                sda_oe <= ~rdata[7];
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
                kind   <= (kind == RX_SEL) ? RX_ADDR : RX_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_MACK;
                ptr    <= ptr + 1'b1;
                cnt    <= '0;
              end else begin
                cnt    <= cnt + 3'd1;
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_lvl) st <= ST_WAIT;
              else         flag <= 1'b1;
            end else if (scl_fall && flag) begin
              flag   <= 1'b0;
              st     <= ST_TX;
              shreg  <= rdata;
              sda_oe <= ~rdata[7];
              cnt    <= '0;
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int MEM_BYTES = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe
);
  localparam int AW = $clog2(MEM_BYTES);

  logic [1:0]    sync_q;
  logic          scl_q, sda_q;
  logic          scl_rise, scl_fall, start_evt, stop_evt;
  logic          busy, mem_we;
  logic [AW-1:0] ptr, mem_waddr;
  logic [7:0]    mem_wdata, rdata;

  i2cm_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(sync_q)
  );
  assign scl_q = sync_q[1];
  assign sda_q = sync_q[0];

  i2cm_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl(scl_q), .sda(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cm_engine #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_lvl(sda_q), .wp(wp_i), .rdata(rdata),
    .ptr(ptr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .sda_oe(sda_oe), .busy(busy)
  );

  i2cm_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rdata)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_q,
  input logic start_evt,
  input logic stop_evt,
  input logic busy,
  input logic sda_oe,
  input logic mem_we,
  input logic wp_i
);
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe);

  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!busy && !sda_oe));

  a_r3_start_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !busy) |=> busy);

  a_r9_wp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !$past(wp_i));

  a_r10_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_q) || $past(stop_evt)));
endmodule

bind i2c_mem_slave i2cm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .start_evt(start_evt),
  .stop_evt(stop_evt), .busy(busy), .sda_oe(sda_oe), .mem_we(mem_we),
  .wp_i(wp_i)
);

// File: tb/i2c_mem_slave_test.sv
module i2c_mem_slave_test;
  localparam int DEPTH = 2048;
  localparam int T     = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_low = 1'b0;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_bus;
  assign sda_bus = ~(sda_low | sda_oe);

  always #5 clk = ~clk;

  i2c_mem_slave #(.MEM_BYTES(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .wp_i(wp), .sda_oe(sda_oe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] mem_m [DEPTH];
  int ptr_m = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] obs_q [$];

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_low = 1'b0; wcyc(T);
    scl = 1'b1;     wcyc(T);
    sda_low = 1'b1; wcyc(T);
    scl = 1'b0;     wcyc(2);
  endtask

  task automatic bus_stop();
    sda_low = 1'b1; wcyc(T);
    scl = 1'b1;     wcyc(T);
    sda_low = 1'b0; wcyc(T);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_low = ~b[i]; wcyc(T);
      scl = 1'b1;      wcyc(T);
      scl = 1'b0;      wcyc(2);
    end
    sda_low = 1'b0; wcyc(T);
    scl = 1'b1;     wcyc(T/2);
    ack = ~sda_bus; wcyc(T/2);
    scl = 1'b0;     wcyc(2);
  endtask

  task automatic get_byte(input bit more, output logic [7:0] v);
    sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wcyc(T);
      scl = 1'b1; wcyc(T/2);
      v[i] = sda_bus; wcyc(T/2);
      scl = 1'b0; wcyc(2);
    end
    sda_low = more; wcyc(T);
    scl = 1'b1;     wcyc(T);
    scl = 1'b0;     wcyc(2);
    sda_low = 1'b0;
  endtask

  // Driver: write transfer, model updated from the requirements.
  task automatic write_txn(int hi, int lo, logic [7:0] data [$]);
    bit ack;
    bus_start();
    put_byte(8'hA0 | 8'(hi << 1), ack);
    check(ack, "R3 select ack", ack, 1);
    put_byte(8'(lo), ack);
    check(ack, "R5 address ack", ack, 1);
    ptr_m = (hi << 8) | lo;
    foreach (data[i]) begin
      put_byte(data[i], ack);
      check(ack, wp ? "R9 protected data ack" : "R6 data ack", ack, 1);
      if (!wp) mem_m[ptr_m] = data[i];
      ptr_m = (ptr_m + 1) % DEPTH;
    end
    bus_stop();
    check(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
  endtask

  // Driver: read transfer, expected bytes pushed for the monitor.
  task automatic read_txn(int hi, int n, string tag);
    bit ack;
    logic [7:0] v;
    bus_start();
    put_byte(8'hA1 | 8'(hi << 1), ack);
    check(ack, "R3 read select ack", ack, 1);
    ptr_m = (hi << 8) | (ptr_m & 8'hFF);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(mem_m[ptr_m]);
      tag_q.push_back(tag);
      get_byte(i < n - 1, v);
      obs_q.push_back(v);
      ptr_m = (ptr_m + 1) % DEPTH;
    end
  endtask

  // Monitor: compares every read byte against the scoreboard.
  initial begin
    forever begin
      wait (obs_q.size() > 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected byte", obs_q.pop_front(), 0);
      end else begin
        logic [7:0] got, expv;
        string tg;
        got = obs_q.pop_front();
        expv = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(got == expv, tg, got, expv);
      end
    end
  end

  // R10 monitor: the pull-down may only move while SCL is low.
  logic oe_prev = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && sda_oe != oe_prev)
        check(!scl, "R10 drive change with SCL low", scl, 0);
      oe_prev = sda_oe;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    logic [7:0] d [$];
    wcyc(3);
    check(sda_oe == 1'b0, "R1 reset released", sda_oe, 0);
    rst_n = 1'b1;
    wcyc(5);

    // R1: a full byte without START draws no acknowledge
    scl = 1'b0; wcyc(T);
    put_byte(8'hA0, ack);
    check(!ack, "R1 no ack before start", ack, 0);
    scl = 1'b1; wcyc(T);

    // R5 R6: three bytes at 0x010
    d = '{8'h11, 8'h22, 8'h33};
    write_txn(0, 8'h10, d);

    // R11 R7 R8: address-only write, then sequential read
    d = '{};
    write_txn(0, 8'h10, d);
    read_txn(0, 3, "R7 R11 sequential read");
    get_byte(1'b0, v);
    check(v == 8'hFF, "R8 released after nack", v, 8'hFF);
    bus_stop();

    // R3: wrong device nibble
    bus_start();
    put_byte(8'h50, ack);
    check(!ack, "R3 no ack on mismatch", ack, 0);
    get_byte(1'b0, v);
    check(v == 8'hFF, "R3 line left released", v, 8'hFF);
    bus_stop();

    // R2: byte after STOP without START
    scl = 1'b0; wcyc(T);
    put_byte(8'hA0, ack);
    check(!ack, "R2 no ack after stop", ack, 0);
    scl = 1'b1; wcyc(T);

    // R4: high select bits reach the array address
    d = '{8'h5A};
    write_txn(5, 8'h10, d);
    d = '{};
    write_txn(0, 8'h10, d);
    read_txn(0, 1, "R4 low page untouched");
    bus_stop();
    write_txn(5, 8'h10, d);
    read_txn(5, 1, "R4 high page data");
    bus_stop();

    // R6: wrap from the last location to zero
    d = '{8'hC1, 8'hC2};
    write_txn(7, 8'hFF, d);
    d = '{};
    write_txn(0, 8'h00, d);
    read_txn(0, 1, "R6 wrapped byte at zero");
    bus_stop();
    write_txn(7, 8'hFF, d);
    read_txn(7, 2, "R6 last location then wrap");
    bus_stop();

    // R9: protected write leaves the array unchanged
    wp = 1'b1;
    d = '{8'hEE, 8'hEF};
    write_txn(0, 8'h10, d);
    wp = 1'b0;
    d = '{};
    write_txn(0, 8'h10, d);
    read_txn(0, 2, "R9 data kept under protect");
    bus_stop();

    wait (obs_q.size() == 0);
    wcyc(5);
    check(exp_q.size() == 0, "R7 all bytes returned", exp_q.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule